// File: doc/BRIEF.md
# Interrupt Vector Receive Latch

This block sits between a bank of level-sensitive interrupt request lines and a processor core. It watches every line for rising and falling levels. When it is idle and a line goes high, it captures that request as one pending vectored interrupt. It then sets a busy flag and fills three 64-bit data words. It also raises a hard-interrupt request toward the core and pulses a wake signal, so that a halted core resumes.

While the busy flag is set, any new rising request is dropped. The exception is a set of lines that rose in the same cycle as the winning line: those are remembered and taken in turn once busy clears, as long as they are still high. A falling level on any line while busy releases the latch. Software reads the status word and the three data words through a small select-driven read port.

Top module: `ivrl_latch`

## Requirements
- R1: A synchronous reset with `rst_n` low clears all of the following: the busy flag, all three data words, `hard_irq`, `wake`, `pend_index` and the remembered losing lines.
- R2: When a line rises while the latch is not busy, `hard_irq` goes to 1 at the next clock edge. From then on, reading the status word (`rd_sel` = 0) returns only bit 5 set (value 0x20).
- R3: The accepted request loads data word 0 (`rd_sel` = 1) with 0x1F in bits 10:6 and the line index in the low bits, so line k reads 0x7C0 + k. Data word 1 (`rd_sel` = 2) and data word 2 (`rd_sel` = 3) are loaded with zero.
- R4: Each acceptance pulses `wake` high for exactly one cycle, in the same cycle that `hard_irq` first shows 1. It also loads `pend_index` with the vector trap type, 0x060 by default. `pend_index` keeps that value until reset.
- R5: When several lines rise in the same cycle while the latch is idle, the lowest-numbered line is accepted.
- R6: A line that rises while the latch is busy changes nothing: the busy flag, `hard_irq` and data word 0 all keep their values.
- R7: A falling level on any line while the latch is busy clears the busy flag and `hard_irq` at the next edge. The data words keep their values.
- R8: A falling level while the latch is not busy changes nothing, and the data words keep their values.
- R9: Lines that rose in the same cycle as the accepted line, but lost arbitration, are accepted one at a time, lowest first. Each is taken in the cycle after busy clears, provided the line is still high.
- R10: A line that stays high without a new rising level, and that is not a remembered loser, is never accepted again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_lines | input | NUM_LINES | Level-sensitive request lines |
| rd_sel | input | 2 | Read select: 0 status, 1 to 3 data words 0 to 2 |
| rd_data | output | WORD_W | Combinational read data |
| hard_irq | output | 1 | Hard-interrupt request to the core (equals busy) |
| wake | output | 1 | One-cycle pulse that releases a halted core |
| pend_index | output | TRAP_W | Pending interrupt index, loaded with the vector trap type |

## Verification
The bench builds the latch with NUM_LINES = 8 and all other parameters left at their defaults. With eight lines, the highest index (line 7) can be reached in a short sequence. The same sequence also exercises a three-way simultaneous rise, in which two losers are replayed one after another. With the default 5-bit tag at shift 6, a 3-bit index leaves clear gaps between the tag bits and the index bits in data word 0, so a misplaced field shows up in the value read back.

// File: rtl/ivrl_pkg.sv
// Package: shared constants and helpers for the interrupt vector receive latch.
// Assumes data words are at most 64 bits wide and that read selects are 2 bits.
package ivrl_pkg;

    localparam int SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        RD_STATUS = 2'd0,
        RD_WORD0  = 2'd1,
        RD_WORD1  = 2'd2,
        RD_WORD2  = 2'd3
    } rd_sel_e;

    // Build the captured word: a tag of all ones at tag_shift, with the line index in the low bits.
    function automatic logic [63:0] pack_vector(input int unsigned idx,
                                                input int unsigned tag_w,
                                                input int unsigned tag_shift);
        logic [63:0] w;
        w = 64'(((64'd1 << tag_w) - 64'd1) << tag_shift);
        w = w | 64'(idx);
        return w;
    endfunction

endpackage

// File: rtl/ivrl_edge.sv
// Module: per-line edge detector.
// It keeps a registered copy of each request line and reports rising and
// falling levels in the cycle in which they appear on the input.
// Assumes the request lines are already synchronous to clk.
module ivrl_edge #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lines,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall,
    output logic         fall_any
);

    logic [N-1:0] prev_q;

    // Purpose: remember last cycle's level of every line.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lines;
    end

    // Purpose: build one rise and one fall detector for each line.
    for (genvar g = 0; g < N; g++) begin : g_line
        assign rise[g] = lines[g] & ~prev_q[g];
        assign fall[g] = ~lines[g] & prev_q[g];
    end

    assign fall_any = |fall;

endmodule

// File: rtl/ivrl_pick.sv
// Module: lowest-index-first picker.
// It turns a candidate vector into a one-hot grant plus the binary index of the winner.
// Assumes IDX_W is at least $clog2(N).
module ivrl_pick #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     cand,
    output logic [N-1:0]     grant,
    output logic [IDX_W-1:0] idx,
    output logic             any
);

    logic [N:0] blocked;

    assign blocked[0] = 1'b0;

    // Purpose: build a prefix chain, so that a line wins only if no lower line is a candidate.
    for (genvar g = 0; g < N; g++) begin : g_chain
        assign grant[g]       = cand[g] & ~blocked[g];
        assign blocked[g + 1] = blocked[g] | cand[g];
    end

    assign any = blocked[N];

    // Purpose: encode the one-hot grant as a binary index.
    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) idx = idx | IDX_W'(i);
        end
    end

endmodule

// File: rtl/ivrl_state.sv
// Module: latch state.
// Holds the busy flag, the three data words, the pending index, the wake
// pulse and the set of lines that lost arbitration.
// Assumes accept is asserted only while busy is clear, and that IDX_W <= TAG_SHIFT.
module ivrl_state #(
    parameter int          N         = 8,
    parameter int          IDX_W     = 3,
    parameter int          WORD_W    = 64,
    parameter int          TAG_W     = 5,
    parameter int          TAG_SHIFT = 6,
    parameter int          TRAP_W    = 9,
    parameter logic [8:0]  TRAP_TYPE = 9'h060
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      lines,
    input  logic [N-1:0]      rise,
    input  logic              fall_any,
    input  logic              accept,
    input  logic [N-1:0]      grant,
    input  logic [IDX_W-1:0]  grant_idx,
    output logic              busy,
    output logic [N-1:0]      deferred,
    output logic [WORD_W-1:0] word0,
    output logic [WORD_W-1:0] word1,
    output logic [WORD_W-1:0] word2,
    output logic              wake,
    output logic [TRAP_W-1:0] pend_index
);
    import ivrl_pkg::*;

    logic [WORD_W-1:0] packed_word;

    // Purpose: format data word 0 for the current winner.
    always_comb begin
        packed_word = WORD_W'(pack_vector(int'(grant_idx), TAG_W, TAG_SHIFT));
    end

    // Purpose: set busy on an accepted request; clear it on any falling level while busy.
    always_ff @(posedge clk) begin
        if (!rst_n)               busy <= 1'b0;
        else if (accept)          busy <= 1'b1;
        else if (busy && fall_any) busy <= 1'b0;
    end

    // Purpose: load the data words and the pending index on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word0      <= '0;
            word1      <= '0;
            word2      <= '0;
            pend_index <= '0;
        end else if (accept) begin
            word0      <= packed_word;
            word1      <= '0;
            word2      <= '0;
            pend_index <= TRAP_W'(TRAP_TYPE);
        end
    end

    // Purpose: produce a one-cycle wake pulse for each acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) wake <= 1'b0;
        else        wake <= accept;
    end

    // Purpose: keep the lines that lost the same-cycle arbitration; drop a line once it goes low.
    always_ff @(posedge clk) begin
        if (!rst_n)      deferred <= '0;
        else if (accept) deferred <= (rise | deferred) & lines & ~grant;
        else             deferred <= deferred & lines;
    end

endmodule

// File: rtl/ivrl_latch.sv
// Module: interrupt vector receive latch (top).
// It captures the first rising request line as one pending vectored interrupt,
// drives the hard-interrupt and wake outputs, and serves a read port for software.
// Assumes synchronous request lines, 2 <= NUM_LINES <= 2**TAG_SHIFT, and WORD_W > TAG_SHIFT + TAG_W.
module ivrl_latch #(
    parameter int          NUM_LINES = 16,
    parameter int          WORD_W    = 64,
    parameter int          TAG_W     = 5,
    parameter int          TAG_SHIFT = 6,
    parameter int          BUSY_BIT  = 5,
    parameter int          TRAP_W    = 9,
    parameter logic [8:0]  TRAP_TYPE = 9'h060
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_lines,
    input  logic [1:0]           rd_sel,
    output logic [WORD_W-1:0]    rd_data,
    output logic                 hard_irq,
    output logic                 wake,
    output logic [TRAP_W-1:0]    pend_index
);
    import ivrl_pkg::*;

    localparam int IDX_W = $clog2(NUM_LINES);

    logic [NUM_LINES-1:0] rise;
    logic [NUM_LINES-1:0] fall;
    logic                 lower_any;
    logic [NUM_LINES-1:0] cand;
    logic [NUM_LINES-1:0] grant;
    logic [IDX_W-1:0]     grant_idx;
    logic                 accept;
    logic                 busy;
    logic [NUM_LINES-1:0] deferred;
    logic [WORD_W-1:0]    word0;
    logic [WORD_W-1:0]    word1;
    logic [WORD_W-1:0]    word2;
    logic [WORD_W-1:0]    status_word;

    ivrl_edge #(.N(NUM_LINES)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .lines    (irq_lines),
        .rise     (rise),
        .fall     (fall),
        .fall_any (lower_any)
    );

    // Purpose: offer new rises and remembered losers only while idle.
    always_comb begin
        cand = busy ? '0 : ((rise | deferred) & irq_lines);
    end

    ivrl_pick #(.N(NUM_LINES), .IDX_W(IDX_W)) u_pick (
        .cand  (cand),
        .grant (grant),
        .idx   (grant_idx),
        .any   (accept)
    );

    ivrl_state #(
        .N         (NUM_LINES),
        .IDX_W     (IDX_W),
        .WORD_W    (WORD_W),
        .TAG_W     (TAG_W),
        .TAG_SHIFT (TAG_SHIFT),
        .TRAP_W    (TRAP_W),
        .TRAP_TYPE (TRAP_TYPE)
    ) u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .lines      (irq_lines),
        .rise       (rise),
        .fall_any   (lower_any),
        .accept     (accept),
        .grant      (grant),
        .grant_idx  (grant_idx),
        .busy       (busy),
        .deferred   (deferred),
        .word0      (word0),
        .word1      (word1),
        .word2      (word2),
        .wake       (wake),
        .pend_index (pend_index)
    );

    assign hard_irq = busy;

    // Purpose: place the busy flag at its bit position in the status word.
    always_comb begin
        status_word           = '0;
        status_word[BUSY_BIT] = busy;
    end

    // Purpose: choose the read data from the select.
    always_comb begin
        case (rd_sel_e'(rd_sel))
            RD_STATUS: rd_data = status_word;
            RD_WORD0:  rd_data = word0;
            RD_WORD1:  rd_data = word1;
            default:   rd_data = word2;
        endcase
    end

endmodule

// File: rtl/ivrl_latch_chk.sv
// Module: assertion checker for ivrl_latch, attached with a bind statement.
// Assumes it sees the top's internal grant, lower_any and word0 signals.
module ivrl_latch_chk #(
    parameter int NUM_LINES = 16,
    parameter int WORD_W    = 64,
    parameter int TAG_W     = 5,
    parameter int TAG_SHIFT = 6
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 hard_irq,
    input logic                 wake,
    input logic                 lower_any,
    input logic [NUM_LINES-1:0] grant,
    input logic [WORD_W-1:0]    word0
);

    a_r4_wake_single: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> !wake);

    a_r4_wake_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> hard_irq);

    a_r3_tag_present: assert property (@(posedge clk) disable iff (!rst_n)
        hard_irq |-> (word0[TAG_SHIFT +: TAG_W] == {TAG_W{1'b1}}));

    a_r6_busy_holds_word: assert property (@(posedge clk) disable iff (!rst_n)
        (hard_irq && !wake) |-> $stable(word0));

    a_r7_release_on_lower: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hard_irq) |-> $past(lower_any));

    a_r5_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

endmodule

bind ivrl_latch ivrl_latch_chk #(
    .NUM_LINES (NUM_LINES),
    .WORD_W    (WORD_W),
    .TAG_W     (TAG_W),
    .TAG_SHIFT (TAG_SHIFT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hard_irq  (hard_irq),
    .wake      (wake),
    .lower_any (lower_any),
    .grant     (grant),
    .word0     (word0)
);

// File: tb/test_ivrl_latch.sv
// Scoreboard bench: the driver task pushes one expected item per cycle, and
// the monitor pops it and compares it just after the following clock edge.
module test_ivrl_latch;

    localparam int CLK_PERIOD = 10;
    localparam int NL         = 8;
    localparam int WATCHDOG   = 2000;

    typedef struct {
        logic        irq;
        logic        wk;
        logic [8:0]  pend;
        logic [63:0] rd;
        string       tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NL-1:0] lines = '0;
    logic [1:0]    sel = '0;
    logic [63:0]   rd_data;
    logic          hard_irq;
    logic          wake;
    logic [8:0]    pend_index;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ivrl_latch #(.NUM_LINES(NL)) i_ivrl_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_lines  (lines),
        .rd_sel     (sel),
        .rd_data    (rd_data),
        .hard_irq   (hard_irq),
        .wake       (wake),
        .pend_index (pend_index)
    );

    task automatic cmp(input string tag, input string what, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, expv);
        end
    endtask

    // Driver: apply one cycle of stimulus and queue what must follow the next edge.
    task automatic step(input logic r, input logic [NL-1:0] l, input logic [1:0] s,
                        input logic ei, input logic ew, input logic [8:0] ep,
                        input logic [63:0] er, input string tag);
        exp_t e;
        @(negedge clk);
        rst_n = r;
        lines = l;
        sel   = s;
        e.irq = ei; e.wk = ew; e.pend = ep; e.rd = er; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: compare the outputs just after each edge against the queued item.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                cmp(e.tag, "hard_irq", 64'(hard_irq), 64'(e.irq));
                cmp(e.tag, "wake", 64'(wake), 64'(e.wk));
                cmp(e.tag, "pend_index", 64'(pend_index), 64'(e.pend));
                cmp(e.tag, "rd_data", rd_data, e.rd);
            end
        end
    end

    // Watchdog: a hung run is counted as a failure and still prints the summary.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        step(0, 8'h00, 2'd0, 0, 0, 9'h000, 64'h0,   "R1 reset status");
        step(0, 8'h00, 2'd1, 0, 0, 9'h000, 64'h0,   "R1 reset word0");
        step(1, 8'h00, 2'd0, 0, 0, 9'h000, 64'h0,   "R1 idle after reset");
        // R2 R3 R4 single request on line 3
        step(1, 8'h08, 2'd1, 1, 1, 9'h060, 64'h7C3, "R2 R3 R4 accept line 3");
        step(1, 8'h08, 2'd0, 1, 0, 9'h060, 64'h20,  "R2 R4 status busy, wake ends");
        step(1, 8'h08, 2'd2, 1, 0, 9'h060, 64'h0,   "R3 word1 zero");
        step(1, 8'h08, 2'd3, 1, 0, 9'h060, 64'h0,   "R3 word2 zero");
        // R6 rise on line 0 while busy
        step(1, 8'h09, 2'd1, 1, 0, 9'h060, 64'h7C3, "R6 rise while busy ignored");
        // R7 line 3 falls: release
        step(1, 8'h01, 2'd0, 0, 0, 9'h060, 64'h0,   "R7 lower clears busy");
        // R10 line 0 still high, no new rise
        step(1, 8'h01, 2'd1, 0, 0, 9'h060, 64'h7C3, "R10 R7 no retrigger, word kept");
        // R8 fall while idle
        step(1, 8'h00, 2'd0, 0, 0, 9'h060, 64'h0,   "R8 lower while idle status");
        step(1, 8'h00, 2'd1, 0, 0, 9'h060, 64'h7C3, "R8 lower while idle word kept");
        // R5 lines 2, 5, 7 rise together
        step(1, 8'hA4, 2'd1, 1, 1, 9'h060, 64'h7C2, "R5 lowest line wins");
        step(1, 8'hA0, 2'd0, 0, 0, 9'h060, 64'h0,   "R7 line 2 falls");
        // R9 replay of losers
        step(1, 8'hA0, 2'd1, 1, 1, 9'h060, 64'h7C5, "R9 deferred line 5 taken");
        step(1, 8'h80, 2'd0, 0, 0, 9'h060, 64'h0,   "R7 line 5 falls");
        step(1, 8'h80, 2'd1, 1, 1, 9'h060, 64'h7C7, "R9 deferred line 7 taken");
        step(1, 8'h00, 2'd0, 0, 0, 9'h060, 64'h0,   "R7 line 7 falls");
        // R1 reset while busy
        step(1, 8'h10, 2'd1, 1, 1, 9'h060, 64'h7C4, "R2 R3 accept line 4");
        step(0, 8'h10, 2'd1, 0, 0, 9'h000, 64'h0,   "R1 reset while busy");
        step(0, 8'h00, 2'd0, 0, 0, 9'h000, 64'h0,   "R1 reset held");
        step(1, 8'h00, 2'd0, 0, 0, 9'h000, 64'h0,   "R1 idle after release");
        repeat (3) @(posedge clk);
        #2;
        cmp("scoreboard", "queue drained", 64'(exp_q.size()), 64'h0);
        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule